// File: doc/BRIEF.md
# Configurable Bidirectional Port Cell

This cell sits between one pad and one switch-matrix lane. Its configuration register sets five things. It sets the direction mode: input, output, bidirectional, or bus repeater. It chooses which of the two group input-enables and which of the two group output-enables the cell obeys. It chooses a clock from the two group clocks or the clock of the adjacent cell. It can invert the outbound data. It selects a registered or a flow-through data path.

Toward the pad the cell drives a data bit and an enable for the tri-state buffer. Toward the matrix it presents the pad value, gated by the selected input-enable. A capture flop holds the last admitted pad value. In repeater mode the cell drives that captured value back onto the pad. The selected clock is brought out so that the next cell can use it as its neighbour clock.

Top module: `cfg_io_cell`

## Requirements
- R1: On a rising `cfg_clk` edge with `cfg_we` high, `cfg_wdata` is loaded into the configuration register. With `cfg_we` low the register keeps its value. The field layout is:
  - bits [1:0]: mode, where 0 = input, 1 = output, 2 = bidirectional and 3 = repeater.
  - bit 2: input-enable select.
  - bit 3: output-enable select.
  - bits [5:4]: clock select.
  - bit 6: invert.
  - bit 7: registered.
- R2: While `rst_n` is low, the configuration register and both data flops are cleared. The cell is then in flow-through input mode with `pad_oe` low, and `to_matrix` is 0 while the selected IE is low.
- R3: `pad_oe` is 0 in input mode. In the other three modes it equals `grp_oe[bit 3]`.
- R4: In output mode `to_matrix` is 0. In the other modes it depends on the data path:
  - Flow-through: `pad_in` while `grp_ie[bit 2]` is high, otherwise the capture flop.
  - Registered: always the capture flop.
- R5: On each rising edge of the selected clock, the capture flop loads `pad_in` if the selected IE is high. Otherwise it keeps its value. This holds in every mode.
- R6: The selected clock is:
  - `grp_clk[0]` for clock select 0.
  - `grp_clk[1]` for clock select 1.
  - `nbr_clk` for clock select 2 or 3.

  `cell_clk` equals the selected clock. Edges on unselected clocks change no flop.
- R7: `pad_out` depends on the data path:
  - Flow-through: the outbound source XOR the invert bit.
  - Registered: the output flop XOR the invert bit. The output flop loads the source on each selected clock edge.

  Inversion therefore never depends on the data path.
- R8: In repeater mode the outbound source is the capture flop. In every other mode it is `from_matrix`. A registered repeater therefore shows a pad value on `pad_out` one selected edge after that value was captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_clk | input | 1 | Configuration write clock |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 8 | Configuration word |
| grp_clk | input | 2 | Group clock sources |
| grp_ie | input | 2 | Group input-enables |
| grp_oe | input | 2 | Group output-enables |
| nbr_clk | input | 1 | Clock selected by the adjacent cell |
| cell_clk | output | 1 | Clock selected by this cell |
| pad_in | input | 1 | Value seen at the pad |
| pad_out | output | 1 | Value driven toward the pad |
| pad_oe | output | 1 | Pad tri-state enable |
| from_matrix | input | 1 | Outbound data from the switch matrix |
| to_matrix | output | 1 | Inbound data to the switch matrix |

## Verification
In registered repeater mode, one selected clock edge does two things at once. It captures a new pad value, and it moves the previously captured value into the output flop. The bench provokes this in two ways. A directed sequence pulses the selected clock on consecutive cycles while `pad_in` changes. Random configurations also land in this mode with random pad data. The judge is `pad_out`: it must trail the capture by exactly one selected edge, while `to_matrix` already shows the new capture. The same edge also holds or loads the capture flop depending on IE, which random IE patterns exercise together with the shift.

// File: rtl/cfg_io_cell.sv
module cfg_io_cell (
  input  logic       rst_n,
  input  logic       cfg_clk,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  input  logic [1:0] grp_clk,
  input  logic [1:0] grp_ie,
  input  logic [1:0] grp_oe,
  input  logic       nbr_clk,
  output logic       cell_clk,
  input  logic       pad_in,
  output logic       pad_out,
  output logic       pad_oe,
  input  logic       from_matrix,
  output logic       to_matrix
);
  localparam logic [1:0] M_IN  = 2'd0;
  localparam logic [1:0] M_OUT = 2'd1;
  localparam logic [1:0] M_REP = 2'd3;

  logic [7:0] cfg_q;
  logic [1:0] mode, clk_sel;
  logic       ie_sel, oe_sel, inv, regd;
  logic       ie, oe, src;
  logic       in_q, out_q;

  assign {regd, inv, clk_sel, oe_sel, ie_sel, mode} = cfg_q;

  always_ff @(posedge cfg_clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;

  assign cell_clk = clk_sel[1] ? nbr_clk : grp_clk[clk_sel[0]];
  assign ie       = grp_ie[ie_sel];
  assign oe       = grp_oe[oe_sel];
  assign src      = (mode == M_REP) ? in_q : from_matrix;

  always_ff @(posedge cell_clk or negedge rst_n)
    if (!rst_n) begin
      in_q  <= 1'b0;
      out_q <= 1'b0;
    end else begin
      if (ie) in_q <= pad_in;
      out_q <= src;
    end

  assign pad_out   = (regd ? out_q : src) ^ inv;
  assign pad_oe    = (mode != M_IN) & oe;
  assign to_matrix = (mode == M_OUT) ? 1'b0 : ((regd || !ie) ? in_q : pad_in);
endmodule

// File: rtl/io_cell_chk.sv
module io_cell_chk (
  input logic       rst_n,
  input logic       cfg_clk,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [7:0] cfg_q,
  input logic       cell_clk,
  input logic       ie,
  input logic       in_q,
  input logic       pad_oe,
  input logic       to_matrix
);
  p_cfg_load_r1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    cfg_we |=> cfg_q == $past(cfg_wdata));
  p_cfg_hold_r1: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
  p_input_quiet_r3: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'd0) |-> !pad_oe);
  p_output_zero_r4: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_q[1:0] == 2'd1) |-> !to_matrix);
  p_capture_hold_r5: assert property (@(posedge cell_clk) disable iff (!rst_n)
    !ie |=> $stable(in_q));
endmodule

bind cfg_io_cell io_cell_chk u_chk (
  .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_q(cfg_q), .cell_clk(cell_clk), .ie(ie), .in_q(in_q),
  .pad_oe(pad_oe), .to_matrix(to_matrix)
);

// File: tb/tb_cfg_io_cell.sv
module tb_cfg_io_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [1:0] grp_clk = '0, grp_ie = '0, grp_oe = '0;
  logic       nbr_clk = 1'b0, pad_in = 1'b0, from_matrix = 1'b0;
  logic       cell_clk, pad_out, pad_oe, to_matrix;

  int checks = 0, errors = 0;
  logic [7:0] mcfg = '0;
  logic m_in = 1'b0, m_out = 1'b0;

  always #10 clk = ~clk;

  cfg_io_cell dut (
    .rst_n(rst_n), .cfg_clk(clk), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .grp_clk(grp_clk), .grp_ie(grp_ie), .grp_oe(grp_oe), .nbr_clk(nbr_clk),
    .cell_clk(cell_clk), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .from_matrix(from_matrix), .to_matrix(to_matrix)
  );

  function automatic int sel_idx();
    return mcfg[5] ? 2 : int'(mcfg[4]);
  endfunction
  function automatic logic src_v();
    return (mcfg[1:0] == 2'd3) ? m_in : from_matrix;
  endfunction
  function automatic logic exp_oe();
    return (mcfg[1:0] != 2'd0) & grp_oe[mcfg[3]];
  endfunction
  function automatic logic exp_tm();
    if (mcfg[1:0] == 2'd1) return 1'b0;
    if (mcfg[7] || !grp_ie[mcfg[2]]) return m_in;
    return pad_in;
  endfunction
  function automatic logic exp_po();
    return (mcfg[7] ? m_out : src_v()) ^ mcfg[6];
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk); #1;
    cfg_we = 1'b0; mcfg = v;
  endtask

  task automatic pulse(input int k);
    logic nin;
    #2;
    if (k == sel_idx()) begin
      nin   = grp_ie[mcfg[2]] ? pad_in : m_in;
      m_out = src_v();
      m_in  = nin;
    end
    if (k == 2) nbr_clk = 1'b1; else grp_clk[k] = 1'b1;
    #1;
    check("R6 cell_clk", cell_clk, k == sel_idx());
    #2;
    if (k == 2) nbr_clk = 1'b0; else grp_clk[k] = 1'b0;
  endtask

  task automatic check_all();
    #3;
    check("R3 pad_oe", pad_oe, exp_oe());
    check("R4 to_matrix", to_matrix, exp_tm());
    check((mcfg[1:0] == 2'd3) ? "R8 pad_out" : "R7 pad_out", pad_out, exp_po());
  endtask

  initial begin : watchdog
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    grp_ie = 2'b00; pad_in = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 pad_oe reset", pad_oe, 1'b0);
    check("R2 to_matrix reset", to_matrix, 1'b0);
    check("R2 pad_out reset", pad_out, 1'b0);
    rst_n = 1'b1;

    // R1 load and hold
    grp_oe = 2'b01;
    write_cfg(8'h01);
    #3; check("R1 load output mode", pad_oe, 1'b1);
    @(negedge clk); cfg_wdata = 8'h00;
    @(negedge clk); #3;
    check("R1 hold without we", pad_oe, 1'b1);
    check("R4 output mode zero", to_matrix, 1'b0);

    // R6/R5 registered input, clock 1
    write_cfg(8'h90);
    @(negedge clk); grp_ie = 2'b11; pad_in = 1'b1;
    pulse(0); #3; check("R6 unselected clock ignored", to_matrix, 1'b0);
    @(negedge clk); pulse(1); #3; check("R5 capture on selected", to_matrix, 1'b1);
    @(negedge clk); grp_ie = 2'b00; pad_in = 1'b0;
    pulse(1); #3; check("R5 hold while IE low", to_matrix, 1'b1);
    write_cfg(8'hA0);
    @(negedge clk); grp_ie = 2'b01;
    pulse(2); #3; check("R6 neighbour clock capture", to_matrix, 1'b0);

    // R8 registered repeater, one-edge lag
    write_cfg(8'h83);
    @(negedge clk); pad_in = 1'b1; pulse(0); #3;
    check("R8 repeater lag", pad_out, 1'b0);
    check("R4 registered capture", to_matrix, 1'b1);
    @(negedge clk); pad_in = 1'b0; pulse(0); #3;
    check("R8 repeater drives capture", pad_out, 1'b1);
    write_cfg(8'hC3); #3;
    check("R7 inverted registered", pad_out, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 8) == 0) write_cfg(8'($urandom));
      @(negedge clk);
      pad_in = 1'($urandom); from_matrix = 1'($urandom);
      grp_ie = 2'($urandom); grp_oe = 2'($urandom);
      if (($urandom % 4) != 0) pulse(int'($urandom % 3));
      check_all();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule